// File: doc/BRIEF.md
# Dual Compare-Match Interval Timer

This block holds two 8-bit interval timers behind a small register port. Each timer divides the system clock through a selectable prescaler, advances an up counter on every prescaled tick and compares the counter against a compare register. When they are equal, the next tick returns the counter to zero, sets the timer's pending flag and toggles its match output. The match output is therefore a square wave of 50% duty whose period is twice the match interval. The match interval is (period + 1) prescaled ticks.

Software writes a new period into a buffer. The buffer reaches the compare register only at a match or while the timer is stopped, so a running interval is never cut short. A mode bit joins the two timers into a single 16-bit timer. In that mode timer 1 holds the high byte, and the match is reported through timer 0's flag and output. Pin multiplexing and the processor sit outside the block.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0, both counters read 0, and `irq` and `matchOut` are 0.
- R2: The prescale field is control bits 3:2. Code 0 divides the clock by 256, code 1 by 64, code 2 by 16 and code 3 by 1. A started counter first advances after one full division.
- R3: A running timer with period P counts 0..P and returns to 0 on the tick after it reads P, so a match occurs every P+1 ticks.
- R4: Each match toggles that timer's `matchOut` bit. The bit changes at no other time.
- R5: A period written while the timer runs takes effect only after the next match. Its buffer reads back the new value at once. While the timer is stopped, the compare register follows the buffer.
- R6: The pending register (address 6, bit i for timer i) sets on a match. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. `irq[i]` is the pending bit gated by the interrupt enable (control bit 4).
- R7: Writing 1 to control bit 1 clears the counter and the prescaler one clock later. The bit always reads 0.
- R8: With the run bit (control bit 0) at 0, the counter holds its value and the prescaler returns to zero. After a restart, the first tick comes a full division later.
- R9: With timer 0 control bit 5 set, the two counters form one 16-bit counter, with timer 1 as the high byte. It is driven by timer 0's run bit, prescaler and clear bit. The match requires both bytes to equal the combined period, and it is signalled only on timer 0's pending bit and `matchOut[0]`.
- R10: With bit 5 clear, the two timers count, match and signal independently. The register addresses are: control 0/3, period 1/4 and count 2/5 for timer 0/1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| irq | output | 2 | Interrupt request per timer |
| matchOut | output | 2 | Toggling match output per timer |

## Verification
The assertions assume that software does not write a clear to the same timer in two consecutive cycles. They also assume the cascade bit changes only while timer 0 is stopped. The directed tasks keep to both rules: every write is followed by a cycle with the strobe low, and each scenario starts from reset, so the mode is set before the run bit. Counter and flag values are sampled on the falling edge, at rising-edge counts worked out from the prescale division and period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NT = 2;
  localparam int AW = 3;
  localparam int RUN_B = 0;
  localparam int CLR_B = 1;
  localparam int PS_LO = 2;
  localparam int IE_B  = 4;
  localparam int CAS_B = 5;
  localparam logic [AW-1:0] PEND_A = AW'(6);

  typedef struct packed {
    logic [NT-1:0]      run;
    logic [NT-1:0]      clr;
    logic [NT-1:0][1:0] psel;
    logic               cascade;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic [AW-1:0]              addr,
  input  logic [CNT_W-1:0]           wrData,
  output logic [CNT_W-1:0]           rdData,
  input  logic [NT-1:0]              matchEv,
  input  logic [NT-1:0][CNT_W-1:0]   count,
  output tmrStrobe_t                 strb,
  output logic [NT-1:0][CNT_W-1:0]   bufPeriod,
  output logic [NT-1:0]              pend,
  output logic [NT-1:0]              irq
);
  logic [NT-1:0]      runQ, ieQ, clrQ;
  logic [NT-1:0][1:0] pselQ;
  logic               casQ;
  logic [NT-1:0][CNT_W-1:0] ctrlView;

  genvar i;
  generate
    for (i = 0; i < NT; i++) begin : g_tmr
      localparam logic [AW-1:0] CTRL_A = AW'(3 * i);
      localparam logic [AW-1:0] PER_A  = AW'(3 * i + 1);
      logic ctrlWr, perWr;
      assign ctrlWr = wrEn && (addr == CTRL_A);
      assign perWr  = wrEn && (addr == PER_A);

      always_ff @(posedge clk) begin
        if (rst) begin
          runQ[i]      <= 1'b0;
          ieQ[i]       <= 1'b0;
          pselQ[i]     <= 2'b00;
          clrQ[i]      <= 1'b0;
          bufPeriod[i] <= '0;
          pend[i]      <= 1'b0;
        end else begin
          clrQ[i] <= ctrlWr && wrData[CLR_B];
          if (ctrlWr) begin
            runQ[i]  <= wrData[RUN_B];
            ieQ[i]   <= wrData[IE_B];
            pselQ[i] <= wrData[PS_LO+1:PS_LO];
          end
          if (perWr) bufPeriod[i] <= wrData;
          if (matchEv[i]) pend[i] <= 1'b1;
          else if (wrEn && addr == PEND_A && !wrData[i]) pend[i] <= 1'b0;
        end
      end

      always_comb begin
        ctrlView[i] = '0;
        ctrlView[i][RUN_B] = runQ[i];
        ctrlView[i][PS_LO+1:PS_LO] = pselQ[i];
        ctrlView[i][IE_B] = ieQ[i];
        if (i == 0) ctrlView[i][CAS_B] = casQ;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) casQ <= 1'b0;
    else if (wrEn && addr == '0) casQ <= wrData[CAS_B];
  end

  assign strb.run     = runQ;
  assign strb.clr     = clrQ;
  assign strb.psel    = pselQ;
  assign strb.cascade = casQ;
  assign irq          = pend & ieQ;

  always_comb begin
    case (addr)
      AW'(0):  rdData = ctrlView[0];
      AW'(1):  rdData = bufPeriod[0];
      AW'(2):  rdData = count[0];
      AW'(3):  rdData = ctrlView[1];
      AW'(4):  rdData = bufPeriod[1];
      AW'(5):  rdData = count[1];
      PEND_A:  rdData = CNT_W'(pend);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tmrStrobe_t               strb,
  input  logic [NT-1:0][CNT_W-1:0] bufPeriod,
  output logic [NT-1:0][CNT_W-1:0] count,
  output logic [NT-1:0]            matchEv,
  output logic [NT-1:0]            matchOut
);
  localparam logic [PS_W-1:0] LIM_A = '1;
  localparam logic [PS_W-1:0] LIM_B = PS_W'((1 << (PS_W - 2)) - 1);
  localparam logic [PS_W-1:0] LIM_C = PS_W'((1 << (PS_W - 4)) - 1);
  localparam logic [PS_W-1:0] LIM_D = '0;

  logic [NT-1:0]            tick;
  logic [NT-1:0][CNT_W-1:0] cmp;
  logic                     hit0, hit1, cas;

  genvar i;
  generate
    for (i = 0; i < NT; i++) begin : g_ps
      logic [PS_W-1:0] psCnt, lim;
      always_comb begin
        case (strb.psel[i])
          2'd0:    lim = LIM_A;
          2'd1:    lim = LIM_B;
          2'd2:    lim = LIM_C;
          default: lim = LIM_D;
        endcase
      end
      assign tick[i] = strb.run[i] && (psCnt == lim);
      always_ff @(posedge clk) begin
        if (rst || !strb.run[i] || strb.clr[i] || psCnt == lim) psCnt <= '0;
        else psCnt <= psCnt + 1'b1;
      end
    end
  endgenerate

  assign cas  = strb.cascade;
  assign hit0 = count[0] == cmp[0];
  assign hit1 = count[1] == cmp[1];
  assign matchEv[0] = tick[0] && hit0 && (!cas || hit1);
  assign matchEv[1] = !cas && tick[1] && hit1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      cmp      <= '0;
      matchOut <= '0;
    end else begin
      if (strb.clr[0]) count[0] <= '0;
      else if (tick[0]) count[0] <= matchEv[0] ? '0 : count[0] + 1'b1;

      if (cas) begin
        if (strb.clr[0]) count[1] <= '0;
        else if (tick[0]) begin
          if (matchEv[0]) count[1] <= '0;
          else if (&count[0]) count[1] <= count[1] + 1'b1;
        end
      end else begin
        if (strb.clr[1]) count[1] <= '0;
        else if (tick[1]) count[1] <= matchEv[1] ? '0 : count[1] + 1'b1;
      end

      if (!strb.run[0] || matchEv[0]) cmp[0] <= bufPeriod[0];
      if (cas ? (!strb.run[0] || matchEv[0]) : (!strb.run[1] || matchEv[1]))
        cmp[1] <= bufPeriod[1];

      matchOut <= matchOut ^ matchEv;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic [1:0]       irq,
  output logic [1:0]       matchOut
);
  tmrStrobe_t               strb;
  logic [NT-1:0][CNT_W-1:0] bufPeriod;
  logic [NT-1:0][CNT_W-1:0] count;
  logic [NT-1:0]            matchEv;
  logic [NT-1:0]            pend;

  tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .matchEv(matchEv), .count(count), .strb(strb),
    .bufPeriod(bufPeriod), .pend(pend), .irq(irq)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PS_W(PS_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .bufPeriod(bufPeriod),
    .count(count), .matchEv(matchEv), .matchOut(matchOut)
  );
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input tmrStrobe_t               strb,
  input logic [NT-1:0]            matchEv,
  input logic [NT-1:0]            matchOut,
  input logic [NT-1:0]            pend,
  input logic [NT-1:0][CNT_W-1:0] count
);
  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    matchEv[0] |=> matchOut[0] != $past(matchOut[0]));
  p_steady_r4: assert property (@(posedge clk) disable iff (rst)
    !matchEv[1] |=> $stable(matchOut[1]));
  p_pend_set_r6: assert property (@(posedge clk) disable iff (rst)
    matchEv[0] |=> pend[0]);
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    strb.clr[0] |=> count[0] == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!strb.run[0] && !strb.clr[0]) |=> $stable(count[0]));
  p_cascade_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    strb.cascade |-> !matchEv[1]);
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .matchEv(matchEv),
  .matchOut(matchOut), .pend(pend), .count(count)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] irq, matchOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  tmr_pair u0 (.clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
               .rdData(rdData), .irq(irq), .matchOut(matchOut));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = 3'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic do_reset();
    rst = 1'b1; wrEn = 1'b0;
    wait_n(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 irq", int'(irq), 0);
    chk("R1 matchOut", int'(matchOut), 0);
  endtask

  task automatic t_prescale();
    int v;
    int div;
    for (int c = 0; c < 4; c++) begin
      div = (c == 0) ? 256 : (c == 1) ? 64 : (c == 2) ? 16 : 1;
      do_reset();
      wr(1, 255);
      wr(0, 1 | (c << 2));
      wait_n(3 * div - 1);
      rd(2, v); chk($sformatf("R2 code %0d before tick", c), v, 2);
      wait_n(1);
      rd(2, v); chk($sformatf("R2 code %0d at tick", c), v, 3);
    end
  endtask

  task automatic t_period();
    int v;
    do_reset();
    wr(1, 4);
    wr(0, 8'h0D);
    wait_n(4);
    rd(2, v); chk("R3 reaches period", v, 4);
    chk("R4 no toggle yet", int'(matchOut[0]), 0);
    wait_n(1);
    rd(2, v); chk("R3 wraps", v, 0);
    chk("R4 first toggle", int'(matchOut[0]), 1);
    wait_n(2);
    rd(2, v); chk("R3 recount", v, 2);
    wait_n(3);
    rd(2, v); chk("R3 second wrap", v, 0);
    chk("R4 second toggle", int'(matchOut[0]), 0);
  endtask

  task automatic t_reload();
    int v;
    do_reset();
    wr(1, 4);
    wr(0, 8'h0D);
    wr(1, 9);
    rd(1, v); chk("R5 buffer readback", v, 9);
    wait_n(4);
    rd(2, v); chk("R5 old period kept", v, 0);
    wait_n(9);
    rd(2, v); chk("R5 new period used", v, 9);
    wait_n(1);
    rd(2, v); chk("R5 new period wrap", v, 0);
    chk("R5 matchOut after two matches", int'(matchOut[0]), 0);
  endtask

  task automatic t_pending();
    int v;
    do_reset();
    wr(1, 2);
    wr(0, 8'h1D);
    wait_n(3);
    wr(0, 8'h1C);
    rd(6, v); chk("R6 pending set", v, 1);
    chk("R6 irq raised", int'(irq), 1);
    wr(6, 8'hFF);
    rd(6, v); chk("R6 write 1 no effect", v, 1);
    wr(0, 8'h0C);
    chk("R6 irq gated by enable", int'(irq), 0);
    rd(6, v); chk("R6 pending kept when disabled", v, 1);
    wr(6, 8'h02);
    rd(6, v); chk("R6 write 0 clears", v, 0);
  endtask

  task automatic t_clear();
    int v;
    do_reset();
    wr(1, 200);
    wr(0, 8'h0D);
    wait_n(10);
    rd(2, v); chk("R7 counted", v, 10);
    wr(0, 8'h0F);
    rd(0, v); chk("R7 clear bit reads 0", v, 8'h0D);
    wait_n(1);
    rd(2, v); chk("R7 counter cleared", v, 0);
    wait_n(3);
    rd(2, v); chk("R7 counts after clear", v, 3);
  endtask

  task automatic t_stop();
    int v;
    do_reset();
    wr(1, 255);
    wr(0, 8'h09);
    wait_n(48);
    rd(2, v); chk("R8 running count", v, 3);
    wr(0, 8'h08);
    wait_n(40);
    rd(2, v); chk("R8 held while stopped", v, 3);
    wr(0, 8'h09);
    wait_n(15);
    rd(2, v); chk("R8 prescaler restarted", v, 3);
    wait_n(1);
    rd(2, v); chk("R8 first tick after restart", v, 4);
  endtask

  task automatic t_cascade();
    int v, w;
    do_reset();
    wr(1, 2);
    wr(4, 1);
    wr(0, 8'h3D);
    wait_n(255);
    rd(2, v); rd(5, w);
    chk("R9 low byte", v, 255); chk("R9 high byte", w, 0);
    wait_n(1);
    rd(2, v); rd(5, w);
    chk("R9 carry low", v, 0); chk("R9 carry high", w, 1);
    wait_n(2);
    rd(2, v); rd(5, w); chk("R9 at period", v + 256 * w, 258);
    rd(6, v); chk("R9 no early match", v, 0);
    wait_n(1);
    rd(2, v); rd(5, w); chk("R9 wrap", v + 256 * w, 0);
    rd(6, v); chk("R9 pending on timer 0 only", v, 1);
    chk("R9 matchOut on timer 0 only", int'(matchOut), 1);
    chk("R9 irq", int'(irq), 1);
  endtask

  task automatic t_independent();
    int v;
    do_reset();
    wr(1, 2);
    wr(4, 4);
    wr(3, 8'h0D);
    wr(0, 8'h0D);
    wait_n(5);
    rd(2, v); chk("R10 timer 0 count", v, 2);
    rd(5, v); chk("R10 timer 1 count", v, 1);
    rd(6, v); chk("R10 both pending", v, 3);
    chk("R10 both matchOut", int'(matchOut), 3);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_prescale();
    t_period();
    t_reload();
    t_pending();
    t_clear();
    t_stop();
    t_cascade();
    t_independent();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule